// File: doc/BRIEF.md
# Framed Serializer with Sync-Burst Generator

This block is the transmit half of a 10-bit embedded-clock serial link. It runs on a bit-rate clock and splits it internally into 12-bit frames. Once per frame it captures a parallel data word, adds a high start bit and a low stop bit around it, and shifts the frame out one bit per clock. The start bit goes first, then data bit 0 up to data bit 9, then the stop bit. Because every frame boundary carries a low-to-high edge, a receiver can recover the word clock from the serial stream.

A receiver acquires lock faster on a training pattern than on live data. To provide one, two sync request inputs are OR-ed together and sampled once per frame. When the combined request has been seen on enough consecutive frames, the block sends a fixed-length burst of training frames in place of data. Each training frame is six ones followed by six zeros. The same burst is sent after reset and after power-down, before any data goes out.

An output-valid flag stands in for the tri-state driver of the serial line. It shows when the line is actually being driven, based on the output-enable, power-down and sync request inputs.

Top module: `framed_sync_serializer`

## Requirements
- R1: Each frame is 12 serial bits, sent one per clock. Bit 0 of the frame is a start bit equal to 1. Bits 1 to 10 are data bits 0 to 9 in that order. Bit 11 is a stop bit equal to 0.
- R2: A frame lasts exactly 12 clocks. `word_stb_o` is high only during the last bit period of each frame (the stop bit), and the next frame is loaded on that clock edge.
- R3: With `cap_rise_i` = 1, `din_i` is captured on the clock edge that ends bit period 0 of a frame. With `cap_rise_i` = 0, it is captured on the edge that ends bit period 6. The captured word is sent in the next frame.
- R4: The request is `sync_a_i` OR `sync_b_i`, sampled at each frame-load edge. A request seen on 6 consecutive load edges makes the frame loaded at the 6th edge a training frame. A request seen on only 5 consecutive edges starts no burst.
- R5: A burst is exactly 1026 training frames, with serial bits 0 to 5 equal to 1 and bits 6 to 11 equal to 0. The request may drop during the burst without shortening it, and data frames resume afterwards.
- R6: `din_i` has no effect on the frames of a burst.
- R7: If the request stays high continuously, the first burst is followed by 5 data frames and then a second 1026-frame burst.
- R8: `ser_valid_o` is high only when `oe_i` = 1, `pwr_ni` = 1, and either the current frame is a training frame or no request is present.
- R9: Driving `oe_i` low only clears `ser_valid_o`; the frame sequence continues unchanged, and when `oe_i` returns high the stream is valid again.
- R10: While `pwr_ni` = 0, `ser_o`, `word_stb_o` and `ser_valid_o` are 0. After `pwr_ni` returns high, or after reset, the first 1026 frames are training frames and data follows.
- R11: While reset is applied, `ser_o` and `word_stb_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ni | input | 1 | Power-down, active low |
| oe_i | input | 1 | Serial output enable |
| cap_rise_i | input | 1 | Capture phase: 1 = rising word-clock edge, 0 = falling |
| sync_a_i | input | 1 | Sync request, first input |
| sync_b_i | input | 1 | Sync request, second input |
| din_i | input | DATA_W | Parallel data word |
| ser_o | output | 1 | Serial data, start bit first |
| ser_valid_o | output | 1 | Serial line actively driven |
| word_stb_o | output | 1 | High during the last bit period of each frame |

## Verification
Every one of the 1024 data words is sent back to back with rising-edge capture. A different word is presented in the second half of each frame, so a capture on the wrong phase or a swapped bit shows up as a data mismatch. A falling-edge sweep then checks that the late value is the one taken. The sync logic is tried with a 5-frame request, which must start nothing, with a 6-frame request that is released inside the burst, and with a request held continuously. Together these separate the qualification threshold, the burst length and the 5-frame gap before a re-trigger. Reset and power-down release are each followed by counting the training frames, while the data input changes on every frame to show that it is ignored.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int FSS_DATA_W     = 10;
  localparam int FSS_SYNC_QUAL  = 6;
  localparam int FSS_BURST_LEN  = 1026;
  localparam int FSS_TRAIN_ONES = 6;

  typedef enum logic {
    CAP_FALL = 1'b0,
    CAP_RISE = 1'b1
  } cap_phase_e;
endpackage

// File: rtl/fss_sync_ctrl.sv
module fss_sync_ctrl #(
  parameter int SYNC_QUAL = 6,
  parameter int BURST_LEN = 1026
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ni,
  input  logic stb_i,
  input  logic req_i,
  output logic train_o,
  output logic in_train_o
);
  localparam int QW = $clog2(SYNC_QUAL);
  localparam int BW = $clog2(BURST_LEN);

  logic [QW-1:0] qual_q;
  logic [BW-1:0] rem_q;
  logic          train_q;
  logic          wake_q;
  logic          busy;
  logic          start;

  // busy: current frame is training and more training frames follow
  assign busy    = train_q && (rem_q != '0);
  assign start   = wake_q || (req_i && !busy && (qual_q == QW'(SYNC_QUAL - 1)));
  assign train_o = start || busy;
  assign in_train_o = train_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qual_q  <= '0;
      rem_q   <= '0;
      train_q <= 1'b0;
      wake_q  <= 1'b1;
    end else if (!pwr_ni) begin
      qual_q  <= '0;
      rem_q   <= '0;
      train_q <= 1'b0;
      wake_q  <= 1'b1;
    end else if (stb_i) begin
      wake_q  <= 1'b0;
      train_q <= train_o;
      if (start)     rem_q <= BW'(BURST_LEN - 1);
      else if (busy) rem_q <= rem_q - 1'b1;
      else           rem_q <= '0;
      if (start || busy) qual_q <= '0;
      else if (req_i)    qual_q <= qual_q + 1'b1;
      else               qual_q <= '0;
    end
  end
endmodule

// File: rtl/fss_shifter.sv
module fss_shifter
  import fss_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int TRAIN_ONES = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ni,
  input  logic              cap_rise_i,
  input  logic              train_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              ser_o,
  output logic              stb_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CW      = $clog2(FRAME_W);
  localparam int HALF    = FRAME_W / 2;
  localparam logic [FRAME_W-1:0] TRAIN_FRAME = {FRAME_W{1'b1}} >> (FRAME_W - TRAIN_ONES);

  logic [CW-1:0]      bit_q;
  logic [DATA_W-1:0]  cap_q;
  logic [FRAME_W-1:0] sh_q;
  logic               cap_en;
  logic [FRAME_W-1:0] next_frame;

  assign stb_o      = (bit_q == CW'(FRAME_W - 1));
  assign cap_en     = (cap_phase_e'(cap_rise_i) == CAP_RISE) ? (bit_q == '0)
                                                             : (bit_q == CW'(HALF));
  assign next_frame = train_i ? TRAIN_FRAME : {1'b0, cap_q, 1'b1};
  assign ser_o      = sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      cap_q <= '0;
      sh_q  <= '0;
    end else if (!pwr_ni) begin
      bit_q <= '0;
      cap_q <= '0;
      sh_q  <= '0;
    end else begin
      bit_q <= stb_o ? '0 : bit_q + 1'b1;
      if (cap_en) cap_q <= din_i;
      sh_q  <= stb_o ? next_frame : {1'b0, sh_q[FRAME_W-1:1]};
    end
  end
endmodule

// File: rtl/framed_sync_serializer.sv
module framed_sync_serializer
  import fss_pkg::*;
#(
  parameter int DATA_W     = FSS_DATA_W,
  parameter int SYNC_QUAL  = FSS_SYNC_QUAL,
  parameter int BURST_LEN  = FSS_BURST_LEN,
  parameter int TRAIN_ONES = FSS_TRAIN_ONES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ni,
  input  logic              oe_i,
  input  logic              cap_rise_i,
  input  logic              sync_a_i,
  input  logic              sync_b_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              ser_o,
  output logic              ser_valid_o,
  output logic              word_stb_o
);
  logic req;
  logic train;
  logic in_train;
  logic stb;

  assign req = sync_a_i | sync_b_i;

  fss_sync_ctrl #(
    .SYNC_QUAL(SYNC_QUAL),
    .BURST_LEN(BURST_LEN)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_ni    (pwr_ni),
    .stb_i     (stb),
    .req_i     (req),
    .train_o   (train),
    .in_train_o(in_train)
  );

  fss_shifter #(
    .DATA_W    (DATA_W),
    .TRAIN_ONES(TRAIN_ONES)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_ni    (pwr_ni),
    .cap_rise_i(cap_rise_i),
    .train_i   (train),
    .din_i     (din_i),
    .ser_o     (ser_o),
    .stb_o     (stb)
  );

  assign word_stb_o  = stb;
  assign ser_valid_o = oe_i & pwr_ni & (in_train | ~req);
endmodule

// File: rtl/fss_checker.sv
module fss_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_ni,
  input logic oe_i,
  input logic ser_o,
  input logic ser_valid_o,
  input logic word_stb_o
);
  AST_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_stb_o && pwr_ni) |=> ser_o) else $error("start bit"); // R1

  AST_STOP_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |-> !ser_o) else $error("stop bit"); // R1

  AST_STB_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |=> !word_stb_o) else $error("strobe spacing"); // R2

  AST_VALID_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_i || !pwr_ni) |-> !ser_valid_o) else $error("valid gate"); // R8

  AST_PD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ni |=> (!ser_o && !word_stb_o)) else $error("power-down quiet"); // R10
endmodule

bind framed_sync_serializer fss_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_ni     (pwr_ni),
  .oe_i       (oe_i),
  .ser_o      (ser_o),
  .ser_valid_o(ser_valid_o),
  .word_stb_o (word_stb_o)
);

// File: tb/tb_framed_sync_serializer.sv
module tb_framed_sync_serializer;
  localparam logic [11:0] TRAIN = 12'h03F;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwr_ni = 1'b1;
  logic       oe = 1'b1;
  logic       cap_rise = 1'b1;
  logic       sync_a = 1'b0;
  logic       sync_b = 1'b0;
  logic [9:0] din = '0;
  logic       ser_o, ser_valid_o, word_stb_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  framed_sync_serializer dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .pwr_ni     (pwr_ni),
    .oe_i       (oe),
    .cap_rise_i (cap_rise),
    .sync_a_i   (sync_a),
    .sync_b_i   (sync_b),
    .din_i      (din),
    .ser_o      (ser_o),
    .ser_valid_o(ser_valid_o),
    .word_stb_o (word_stb_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [11:0] dframe(input logic [9:0] d);
    return {1'b0, d, 1'b1};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // collect one frame; drive a at bit 0, b at bit 3; valid sampled at bit 6
  task automatic grab(input logic [9:0] a, input logic [9:0] b,
                      output logic [11:0] f, output logic vm);
    while (!word_stb_o) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      f[i] = ser_o;
      if (i == 0) din = a;
      if (i == 3) din = b;
      if (i == 6) vm = ser_valid_o;
    end
  endtask

  task automatic run_burst(input bit drop, output int pre, output int n,
                           output logic [11:0] nxt, output logic [9:0] last_d,
                           output logic pre_v, output logic tr_v);
    logic [11:0] f;
    logic        vm;
    logic [9:0]  d;
    pre = 0; n = 0; pre_v = 1'b0; tr_v = 1'b1; last_d = '0; nxt = '0;
    forever begin
      d = 10'(n * 37 + pre * 11 + 5);
      grab(d, d, f, vm);
      if (f == TRAIN) begin
        if (drop && n == 0) begin sync_a = 1'b0; sync_b = 1'b0; end
        n++;
        tr_v &= vm;
        last_d = d;
      end else if (n == 0) begin
        pre++;
        pre_v |= vm;
        if (pre > 40) break;
      end else begin
        nxt = f;
        break;
      end
    end
  endtask

  initial begin
    int pre, n, pre2, n2;
    logic [11:0] f, nxt;
    logic [9:0]  ld, pa, pb;
    logic pv, tv, vm;

    repeat (3) @(negedge clk);
    chk(ser_o == 1'b0 && word_stb_o == 1'b0, "R11 reset outputs", {ser_o, word_stb_o}, 0);
    rst_ni = 1'b1;

    // R10/R5/R6: burst after reset, data changes every frame
    run_burst(1'b0, pre, n, nxt, ld, pv, tv);
    chk(pre == 0, "R10 no data before reset burst", pre, 0);
    chk(n == 1026, "R5 R10 reset burst length", n, 1026);
    chk(nxt == dframe(ld), "R6 first data after burst", nxt, dframe(ld));
    chk(tv == 1'b1, "R8 valid during burst", tv, 1);

    // R1/R3: every data word, rising capture
    cap_rise = 1'b1;
    pa = '0; pb = '0;
    for (int k = 0; k <= 1024; k++) begin
      logic [9:0] a, b;
      a = 10'(k);
      b = ~a;
      grab(a, b, f, vm);
      if (k > 0) chk(f == dframe(pa), "R1 R3 rising capture frame", f, dframe(pa));
      pa = a;
    end

    // R3: falling capture takes the late value
    cap_rise = 1'b0;
    grab(10'h0, 10'h0, f, vm);
    for (int k = 0; k <= 64; k++) begin
      logic [9:0] a, b;
      a = 10'(k * 37);
      b = 10'(k * 5 + 3) ^ 10'h2AA;
      grab(a, b, f, vm);
      if (k > 0) chk(f == dframe(pb), "R3 falling capture frame", f, dframe(pb));
      pb = b;
    end
    cap_rise = 1'b1;
    grab(10'h155, 10'h155, f, vm);

    // R9/R8: output enable only gates valid
    oe = 1'b0;
    for (int k = 0; k < 4; k++) begin
      grab(10'h155, 10'h155, f, vm);
      chk(f == dframe(10'h155) && vm == 1'b0, "R9 R8 oe low stream kept", {f, vm}, {dframe(10'h155), 1'b0});
    end
    oe = 1'b1;
    grab(10'h0F0, 10'h0F0, f, vm);
    chk(f == dframe(10'h155) && vm == 1'b1, "R9 oe restored", {f, vm}, {dframe(10'h155), 1'b1});

    // R4: request held on only 5 load edges
    sync_b = 1'b1;
    for (int k = 0; k < 5; k++) begin
      grab(10'h0F0, 10'h0F0, f, vm);
      chk(f != TRAIN, "R4 short request no burst", f, 0);
      chk(vm == 1'b0, "R8 valid low while request pending", vm, 0);
    end
    sync_b = 1'b0;
    for (int k = 0; k < 8; k++) begin
      grab(10'h0F0, 10'h0F0, f, vm);
      chk(f == dframe(10'h0F0), "R4 data after short request", f, dframe(10'h0F0));
    end

    // R4/R5: qualified request released inside burst
    sync_b = 1'b1;
    run_burst(1'b1, pre, n, nxt, ld, pv, tv);
    chk(pre == 5, "R4 frames before burst", pre, 5);
    chk(n == 1026, "R5 burst length after release", n, 1026);
    chk(nxt == dframe(ld), "R5 R6 data resumes", nxt, dframe(ld));
    chk(pv == 1'b0, "R8 valid low during qualification", pv, 0);

    // R7: request held through and past the burst
    grab(10'h0F0, 10'h0F0, f, vm);
    sync_a = 1'b1;
    run_burst(1'b0, pre, n, nxt, ld, pv, tv);
    run_burst(1'b0, pre2, n2, nxt, ld, pv, tv);
    sync_a = 1'b0;
    chk(pre == 5 && n == 1026, "R7 first burst", n, 1026);
    chk(pre2 + 1 == 5, "R7 data gap between bursts", pre2 + 1, 5);
    chk(n2 == 1026, "R7 second burst", n2, 1026);
    chk(pv == 1'b0 && tv == 1'b1, "R8 valid gap/burst with request", {pv, tv}, 1);
    for (int k = 0; k < 8; k++) begin
      grab(10'h233, 10'h233, f, vm);
      chk(f != TRAIN, "R7 no third burst after release", f, 0);
    end

    // R10: power-down
    @(negedge clk);
    pwr_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(ser_o == 1'b0 && word_stb_o == 1'b0 && ser_valid_o == 1'b0,
        "R10 outputs quiet in power-down", {ser_o, word_stb_o, ser_valid_o}, 0);
    repeat (30) @(negedge clk);
    chk(word_stb_o == 1'b0 && ser_valid_o == 1'b0, "R10 still quiet", {word_stb_o, ser_valid_o}, 0);
    pwr_ni = 1'b1;
    run_burst(1'b0, pre, n, nxt, ld, pv, tv);
    chk(pre == 0 && n == 1026, "R10 wake burst", n, 1026);
    chk(nxt == dframe(ld), "R10 data after wake burst", nxt, dframe(ld));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule